// File: doc/BRIEF.md
# Programmable Four-Sided Routing Junction

This block sits at the crossing of four routing channels in a programmable fabric: north, east, south and west. Every side brings in a set of input tracks and drives out a set of output tracks (4 of each by default, indexed from 0). Each output track may be fed from one candidate track on each of the three other sides. Every such candidate connection has its own configuration flip-flop. An output track is the logical OR of the candidate inputs whose bits are set.

A compile-time parameter selects which input track is the candidate on each side. In the same-index pattern, a track only reaches tracks with the same number. In the rotated pattern, the index changes from side to side, so a signal can move to another track number as it turns a corner. That pattern gives better routability.

The 48 configuration bits load serially. While the load strobe is high, one bit shifts in on every rising clock edge. All outputs are held at 0 during that time, so a half-loaded pattern never reaches the channels.

Top module: `sbox_top`

## Requirements
- R1: An active-low asynchronous reset clears every configuration bit, so all output tracks are 0 after reset whatever the inputs are.
- R2: While `cfg_en` is 1, each rising edge shifts `cfg_din` into the chain, and all sixteen output tracks read 0.
- R3: Sides are numbered north=0, east=1, south=2, west=3. The bit for destination side d, track j and candidate rank k sits at index d*12 + j*3 + k. Rank k counts the other three sides in ascending side number. The first bit shifted in lands at index 0 after 48 shifts, and the last bit lands at index 47.
- R4: With `WILTON`=0, destination track j on any side takes its candidate input from track j of each other side.
- R5: With `WILTON`=1, let r = (destination side − source side) mod 4 and let N be the track count. When source track i enters the junction, it leaves on track i if r=2, on track (N−i) mod N if r=1, and on track (i+1) mod N if r=3.
- R6: An output track is the OR of all enabled candidate inputs feeding it. When more than one candidate is enabled for one output, the bench flags that configuration.
- R7: While `cfg_en` is 0, the configuration does not change, whatever `cfg_din` does.
- R8: An input track with no enabled connection to an output has no effect on that output.
- R9: With `WILTON`=0, west track 1 can reach only north track 1, even when all west-to-north bits are set. With `WILTON`=1, the same bits carry it to north track 3.

Bit positions (LSB first) in the packed vectors used below: north tracks occupy [3:0], east [7:4], south [11:8] and west [15:12].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset of the configuration chain |
| cfg_en | input | 1 | Load strobe: shift one bit per edge and blank the outputs |
| cfg_din | input | 1 | Serial configuration data |
| trk_in_n | input | TRACKS | North input tracks |
| trk_in_e | input | TRACKS | East input tracks |
| trk_in_s | input | TRACKS | South input tracks |
| trk_in_w | input | TRACKS | West input tracks |
| trk_out_n | output | TRACKS | North output tracks |
| trk_out_e | output | TRACKS | East output tracks |
| trk_out_s | output | TRACKS | South output tracks |
| trk_out_w | output | TRACKS | West output tracks |

## Verification
The track path has no registers, so an output follows its inputs and `cfg_en` in the same cycle. The bench changes inputs on the falling edge and samples 1 ns later. A new configuration takes effect after exactly 48 rising edges with `cfg_en` high. The bench therefore drops the strobe on the falling edge after the 48th shift, and only then applies track stimulus. The blanking check is sampled in the middle of a load, one falling edge after the previous shift.

// File: rtl/sbox_pkg.sv
package sbox_pkg;

    localparam int NUM_SIDES = 4;
    localparam int NUM_CAND  = NUM_SIDES - 1;

    typedef enum logic [1:0] {
        SIDE_N = 2'd0,
        SIDE_E = 2'd1,
        SIDE_S = 2'd2,
        SIDE_W = 2'd3
    } side_e;

    // Source side for candidate rank k of destination side d.
    // The ranks list the other sides in ascending order.
    function automatic int cand_side(input int d, input int k);
        return (k < d) ? k : k + 1;
    endfunction

    // Source track that feeds destination track j on side d from side s.
    function automatic int cand_track(input int d, input int s, input int j,
                                      input int ntrk, input bit rotated);
        int r;
        if (!rotated) return j;
        r = (d - s + NUM_SIDES) % NUM_SIDES;
        case (r)
            1:       return (ntrk - j) % ntrk;
            3:       return (j - 1 + ntrk) % ntrk;
            default: return j;
        endcase
    endfunction

endpackage

// File: rtl/sbox_cfg_chain.sv
module sbox_cfg_chain #(
    parameter int LEN = 48
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           shift,
    input  logic           din,
    output logic [LEN-1:0] q
);

    generate
        if (LEN == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     q <= '0;
                else if (shift) q <= din;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)     q <= '0;
                else if (shift) q <= {din, q[LEN-1:1]};
            end
        end
    endgenerate

endmodule

// File: rtl/sbox_track_mux.sv
module sbox_track_mux #(
    parameter int NSRC = 3
) (
    input  logic [NSRC-1:0] cand,
    input  logic [NSRC-1:0] sel,
    input  logic            blank,
    output logic            y
);

    always_comb begin
        y = (|(cand & sel)) & ~blank;
    end

endmodule

// File: rtl/sbox_top.sv
module sbox_top
    import sbox_pkg::*;
#(
    parameter int TRACKS = 4,
    parameter bit WILTON = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic              cfg_din,
    input  logic [TRACKS-1:0] trk_in_n,
    input  logic [TRACKS-1:0] trk_in_e,
    input  logic [TRACKS-1:0] trk_in_s,
    input  logic [TRACKS-1:0] trk_in_w,
    output logic [TRACKS-1:0] trk_out_n,
    output logic [TRACKS-1:0] trk_out_e,
    output logic [TRACKS-1:0] trk_out_s,
    output logic [TRACKS-1:0] trk_out_w
);

    localparam int PER_SIDE = TRACKS * NUM_CAND;
    localparam int CFG_LEN  = NUM_SIDES * PER_SIDE;

    logic [CFG_LEN-1:0]                   cfg_q;
    logic [NUM_SIDES-1:0][TRACKS-1:0]     tin;
    logic [NUM_SIDES-1:0][TRACKS-1:0]     tout;
    logic [NUM_SIDES-1:0][TRACKS-1:0][NUM_CAND-1:0] cand_v;

    assign tin[SIDE_N] = trk_in_n;
    assign tin[SIDE_E] = trk_in_e;
    assign tin[SIDE_S] = trk_in_s;
    assign tin[SIDE_W] = trk_in_w;

    sbox_cfg_chain #(.LEN(CFG_LEN)) u_chain (
        .clk   (clk),
        .rst_n (rst_n),
        .shift (cfg_en),
        .din   (cfg_din),
        .q     (cfg_q)
    );

    for (genvar d = 0; d < NUM_SIDES; d++) begin : g_side
        for (genvar j = 0; j < TRACKS; j++) begin : g_trk
            for (genvar k = 0; k < NUM_CAND; k++) begin : g_cand
                localparam int SRC_S = cand_side(d, k);
                localparam int SRC_T = cand_track(d, SRC_S, j, TRACKS, WILTON);
                assign cand_v[d][j][k] = tin[SRC_S][SRC_T];
            end
            sbox_track_mux #(.NSRC(NUM_CAND)) u_mux (
                .cand  (cand_v[d][j]),
                .sel   (cfg_q[d*PER_SIDE + j*NUM_CAND +: NUM_CAND]),
                .blank (cfg_en),
                .y     (tout[d][j])
            );
        end
    end

    assign trk_out_n = tout[SIDE_N];
    assign trk_out_e = tout[SIDE_E];
    assign trk_out_s = tout[SIDE_S];
    assign trk_out_w = tout[SIDE_W];

endmodule

// File: rtl/sbox_checker.sv
module sbox_checker #(
    parameter int CFG_LEN = 48,
    parameter int TRACKS  = 4
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  cfg_en,
    input logic                  cfg_din,
    input logic [CFG_LEN-1:0]    cfg_q,
    input logic [4*TRACKS-1:0]   tin,
    input logic [4*TRACKS-1:0]   tout
);

    p_blank_while_loading_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |-> (tout == '0));

    p_shift_one_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_en |=> (cfg_q[CFG_LEN-1] == $past(cfg_din)) &&
                   (cfg_q[CFG_LEN-2:0] == $past(cfg_q[CFG_LEN-1:1])));

    p_cfg_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> $stable(cfg_q));

    p_empty_cfg_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q == '0) |-> (tout == '0));

    p_no_source_no_drive_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (tin == '0) |-> (tout == '0));

endmodule

bind sbox_top sbox_checker #(
    .CFG_LEN (CFG_LEN),
    .TRACKS  (TRACKS)
) u_sbox_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .cfg_en  (cfg_en),
    .cfg_din (cfg_din),
    .cfg_q   (cfg_q),
    .tin     ({trk_in_w, trk_in_s, trk_in_e, trk_in_n}),
    .tout    ({trk_out_w, trk_out_s, trk_out_e, trk_out_n})
);

// File: tb/sbox_top_bench.sv
`timescale 1ns/1ps
module sbox_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_en_p = 1'b0;
    logic        cfg_en_w = 1'b0;
    logic        cfg_din = 1'b0;
    logic [15:0] tin = '0;
    logic [15:0] out_p, out_w;
    int          total = 0;
    int          bad = 0;
    bit          done = 1'b0;

    always #4 clk = ~clk;

    sbox_top #(.TRACKS(4), .WILTON(1'b0)) u_sbox_top (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en_p), .cfg_din(cfg_din),
        .trk_in_n(tin[3:0]), .trk_in_e(tin[7:4]), .trk_in_s(tin[11:8]), .trk_in_w(tin[15:12]),
        .trk_out_n(out_p[3:0]), .trk_out_e(out_p[7:4]), .trk_out_s(out_p[11:8]), .trk_out_w(out_p[15:12])
    );

    sbox_top #(.TRACKS(4), .WILTON(1'b1)) u_sbox_top_wilton (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en_w), .cfg_din(cfg_din),
        .trk_in_n(tin[3:0]), .trk_in_e(tin[7:4]), .trk_in_s(tin[11:8]), .trk_in_w(tin[15:12]),
        .trk_out_n(out_w[3:0]), .trk_out_e(out_w[7:4]), .trk_out_s(out_w[11:8]), .trk_out_w(out_w[15:12])
    );

    // {rotated, config, inputs, expected outputs}
    localparam int NVEC = 10;
    localparam logic [80:0] VEC [NVEC] = '{
        {1'b0, 48'h0000_0000_0020, 16'h2000, 16'h0002},
        {1'b0, 48'h0000_0000_0020, 16'h4000, 16'h0000},
        {1'b0, 48'h0000_0000_3000, 16'h0001, 16'h0010},
        {1'b0, 48'h0000_0000_3000, 16'h0100, 16'h0010},
        {1'b0, 48'h0000_4000_0000, 16'h0004, 16'h0400},
        {1'b1, 48'h0000_0000_0800, 16'h2000, 16'h0008},
        {1'b1, 48'h0000_0001_0000, 16'h0100, 16'h0020},
        {1'b1, 48'h0000_4000_0000, 16'h0004, 16'h0400},
        {1'b1, 48'h4000_0000_0000, 16'h0080, 16'h8000},
        {1'b1, 48'h0010_0000_0000, 16'h0008, 16'h1000}
    };

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic load(input bit rot, input logic [47:0] c, input bit midchk);
        for (int b = 0; b < 48; b++) begin
            @(negedge clk);
            cfg_din = c[b];
            if (rot) cfg_en_w = 1'b1; else cfg_en_p = 1'b1;
            if (midchk && b == 24) begin
                #1;
                check("R2 blank during load", rot ? out_w : out_p, 16'h0000);
            end
        end
        @(negedge clk);
        cfg_en_p = 1'b0;
        cfg_en_w = 1'b0;
        cfg_din  = 1'b0;
    endtask

    task automatic apply(input logic [15:0] v);
        @(negedge clk);
        tin = v;
        #1;
    endtask

    function automatic int multi_driven(input logic [47:0] c);
        int n = 0;
        for (int o = 0; o < 16; o++)
            if ($countones(c[o*3 +: 3]) > 1) n++;
        return n;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset clears configuration
        tin = 16'hFFFF;
        repeat (3) @(posedge clk);
        #1;
        check("R1 planar after reset", out_p, 16'h0000);
        check("R1 rotated after reset", out_w, 16'h0000);
        @(negedge clk);
        rst_n = 1'b1;
        apply(16'hFFFF);
        check("R1 planar out of reset", out_p, 16'h0000);
        check("R1 rotated out of reset", out_w, 16'h0000);

        // vector table: R4 planar / R5 rotated
        for (int v = 0; v < NVEC; v++) begin
            load(VEC[v][80], VEC[v][79:32], 1'b0);
            apply(VEC[v][31:16]);
            check(VEC[v][80] ? "R5 table" : "R4 table",
                  VEC[v][80] ? out_w : out_p, VEC[v][15:0]);
        end

        // R3: bit ordering at both ends of the chain
        load(1'b0, 48'h0000_0000_0001, 1'b0);
        apply(16'h0010);
        check("R3 first bit north0 from east0", out_p, 16'h0001);
        load(1'b0, 48'h8000_0000_0000, 1'b0);
        apply(16'h0800);
        check("R3 last bit west3 from south3", out_p, 16'h8000);

        // R9: all west-to-north bits set, west track 1 driven
        load(1'b0, 48'h0000_0000_0924, 1'b0);
        load(1'b1, 48'h0000_0000_0924, 1'b0);
        apply(16'h2000);
        check("R9 planar keeps index", out_p, 16'h0002);
        check("R9 rotated reaches north3", out_w, 16'h0008);

        // R6: full configuration, OR of sources, fan-out from north0
        load(1'b0, 48'hFFFF_FFFF_FFFF, 1'b0);
        load(1'b1, 48'hFFFF_FFFF_FFFF, 1'b0);
        apply(16'h0001);
        check("R6 planar fan-out", out_p, 16'h1110);
        check("R6 rotated fan-out", out_w, 16'h2110);
        total++;
        if (multi_driven(48'h0000_0000_3000) != 1) begin
            bad++;
            $display("FAIL R6 conflict flag: actual=%0d expected=1", multi_driven(48'h3000));
        end
        total++;
        if (multi_driven(48'h0000_0000_0020) != 0) begin
            bad++;
            $display("FAIL R6 conflict flag: actual=%0d expected=0", multi_driven(48'h20));
        end
        if (multi_driven(48'hFFFF_FFFF_FFFF) != 0)
            $display("NOTE R6: full configuration drives %0d outputs from several sources",
                     multi_driven(48'hFFFF_FFFF_FFFF));

        // R2: blanking in the middle of a reload
        apply(16'hFFFF);
        load(1'b0, 48'h0000_0000_0020, 1'b1);

        // R7: configuration held while strobe is low
        for (int t = 0; t < 10; t++) begin
            @(negedge clk);
            cfg_din = t[0];
        end
        apply(16'h2000);
        check("R7 config held", out_p, 16'h0002);

        // R8: unconnected inputs do nothing
        apply(16'hDFFF);
        check("R8 unconnected inputs", out_p, 16'h0000);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule